// File: doc/BRIEF.md
# Leaf Page Permission Decoder

This block takes the access fields of a final-level translation descriptor, plus the restrictions collected from the table levels above it, and produces six independent access flags. The flags are read, write and execute for the privileged level and the same three for the unprivileged level. A page-walk engine presents one descriptor per cycle together with a valid strobe. One cycle later the block returns the combined permissions.

The block supports two kinds of translation regime. In the two-privilege regime, a single descriptor serves both the privileged and the user level. In the single-privilege regime, only the privileged level exists. Each regime has its own rules for decoding the leaf field and its own rules for applying table-level restrictions. A hierarchical-disable input bypasses every table-level restriction. The privileged-execute rule blocks execution from any page that the leaf field makes writable by user code.

Top module: `perm_decode_top`

## Requirements
- R1: In the two-privilege regime (`regime_i`=0), the leaf field `ap_i` is decoded as follows. Bit 1 is read-only and bit 0 is user-access. 00 gives privileged read/write and no user access. 01 gives read/write at both levels. 10 gives privileged read only. 11 gives read only at both levels.
- R2: In the two-privilege regime, privileged execute is set only when `pxn_i` is 0 and the leaf field is not 01, which is the user-writable encoding. This rule uses the leaf value before any table restriction. User execute is set when `uxn_i` is 0.
- R3: In the single-privilege regime (`regime_i`=1):
  - All three user flags are 0.
  - Privileged read is 1.
  - Privileged write is the inverse of `ap_i[1]`.
  - Privileged execute is the inverse of `uxn_i`.
  - `ap_i[0]` and `pxn_i` are ignored.
- R4: In the two-privilege regime, the table restriction `tbl_ap_i` acts as follows. 01 clears user read and user write. 10 clears privileged write and user write. 11 clears privileged write, user read and user write. 00 changes nothing.
- R5: In the single-privilege regime, `tbl_ap_i[1]` clears privileged write and `tbl_uxn_i` clears privileged execute. `tbl_ap_i[0]` and `tbl_pxn_i` have no effect.
- R6: In the two-privilege regime, `tbl_pxn_i` clears privileged execute and `tbl_uxn_i` clears user execute.
- R7: When `hier_dis_i` is 1, none of `tbl_ap_i`, `tbl_pxn_i` or `tbl_uxn_i` affects any output.
- R8: Results appear on the outputs on the rising edge that samples `valid_i`=1. On that same edge, `valid_o` rises for one cycle per accepted input.
- R9: While `valid_i` is 0, the six permission outputs keep their previous values.
- R10: When `rst_ni` is low, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Descriptor fields are valid |
| regime_i | input | 1 | 0 = two-privilege regime, 1 = single-privilege regime |
| ap_i | input | 2 | Leaf field: bit 1 read-only, bit 0 user access |
| pxn_i | input | 1 | Leaf privileged execute-never |
| uxn_i | input | 1 | Leaf unprivileged execute-never (plain execute-never in single regime) |
| tbl_ap_i | input | 2 | Accumulated table-level access restriction |
| tbl_pxn_i | input | 1 | Accumulated table-level privileged execute-never |
| tbl_uxn_i | input | 1 | Accumulated table-level unprivileged execute-never |
| hier_dis_i | input | 1 | Ignore all table-level restrictions |
| valid_o | output | 1 | Outputs carry a new result |
| priv_r_o | output | 1 | Privileged read allowed |
| priv_w_o | output | 1 | Privileged write allowed |
| priv_x_o | output | 1 | Privileged execute allowed |
| user_r_o | output | 1 | Unprivileged read allowed |
| user_w_o | output | 1 | Unprivileged write allowed |
| user_x_o | output | 1 | Unprivileged execute allowed |

## Verification
The only state is the output register, so every fault shows up at the ports on the cycle right after the stimulus that caused it. A wrong permission bit appears in the next result. A lost or duplicated strobe shows up as a mismatch between the number of results and the number of inputs. A register that updates without a strobe becomes visible in the idle gap that follows. The stimulus covers every leaf field, table restriction, execute-never combination and hierarchical-disable setting in both regimes. Idle cycles are inserted between some of the results to expose hold faults.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic {
    REGIME_TWO = 1'b0,
    REGIME_ONE = 1'b1
  } regime_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rwx_t;

  typedef struct packed {
    rwx_t priv;
    rwx_t user;
  } perm_t;

  localparam int unsigned PERM_W = $bits(perm_t);
endpackage

// File: rtl/perm_leaf_dec.sv
module perm_leaf_dec
  import perm_pkg::*;
(
  input  regime_e    regime_i,
  input  logic [1:0] ap_i,
  input  logic       pxn_i,
  input  logic       uxn_i,
  output perm_t      perm_o
);
  logic user_wr;

  always_comb begin
    perm_o  = '0;
    user_wr = 1'b0;
    if (regime_i == REGIME_TWO) begin
      unique case (ap_i)
        2'b00: begin perm_o.priv.r = 1'b1; perm_o.priv.w = 1'b1; end
        2'b01: begin
          perm_o.priv.r = 1'b1; perm_o.priv.w = 1'b1;
          perm_o.user.r = 1'b1; perm_o.user.w = 1'b1;
        end
        2'b10: perm_o.priv.r = 1'b1;
        default: begin perm_o.priv.r = 1'b1; perm_o.user.r = 1'b1; end
      endcase
      user_wr       = perm_o.user.w;
      // user-writable pages are never privileged-executable
      perm_o.priv.x = ~pxn_i & ~user_wr;
      perm_o.user.x = ~uxn_i;
    end else begin
      perm_o.priv.r = 1'b1;
      perm_o.priv.w = ~ap_i[1];
      perm_o.priv.x = ~uxn_i;
    end
  end
endmodule

// File: rtl/perm_tbl_apply.sv
module perm_tbl_apply
  import perm_pkg::*;
(
  input  regime_e    regime_i,
  input  perm_t      perm_i,
  input  logic [1:0] tbl_ap_i,
  input  logic       tbl_pxn_i,
  input  logic       tbl_uxn_i,
  input  logic       hier_dis_i,
  output perm_t      perm_o
);
  always_comb begin
    perm_o = perm_i;
    if (!hier_dis_i) begin
      if (regime_i == REGIME_TWO) begin
        if (tbl_ap_i[0]) begin perm_o.user.r = 1'b0; perm_o.user.w = 1'b0; end
        if (tbl_ap_i[1]) begin perm_o.priv.w = 1'b0; perm_o.user.w = 1'b0; end
        if (tbl_pxn_i) perm_o.priv.x = 1'b0;
        if (tbl_uxn_i) perm_o.user.x = 1'b0;
      end else begin
        if (tbl_ap_i[1]) perm_o.priv.w = 1'b0;
        // execute-never of the single regime lives in the unprivileged slot
        if (tbl_uxn_i) perm_o.priv.x = 1'b0;
      end
    end
  end
endmodule

// File: rtl/perm_decode_top.sv
module perm_decode_top
  import perm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       regime_i,
  input  logic [1:0] ap_i,
  input  logic       pxn_i,
  input  logic       uxn_i,
  input  logic [1:0] tbl_ap_i,
  input  logic       tbl_pxn_i,
  input  logic       tbl_uxn_i,
  input  logic       hier_dis_i,
  output logic       valid_o,
  output logic       priv_r_o,
  output logic       priv_w_o,
  output logic       priv_x_o,
  output logic       user_r_o,
  output logic       user_w_o,
  output logic       user_x_o
);
  regime_e regime;
  perm_t   leaf_perm, final_perm, perm_q;

  assign regime = regime_e'(regime_i);

  perm_leaf_dec i_leaf (
    .regime_i (regime),
    .ap_i     (ap_i),
    .pxn_i    (pxn_i),
    .uxn_i    (uxn_i),
    .perm_o   (leaf_perm)
  );

  perm_tbl_apply i_tbl (
    .regime_i   (regime),
    .perm_i     (leaf_perm),
    .tbl_ap_i   (tbl_ap_i),
    .tbl_pxn_i  (tbl_pxn_i),
    .tbl_uxn_i  (tbl_uxn_i),
    .hier_dis_i (hier_dis_i),
    .perm_o     (final_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      perm_q  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) perm_q <= final_perm;
    end
  end

  assign priv_r_o = perm_q.priv.r;
  assign priv_w_o = perm_q.priv.w;
  assign priv_x_o = perm_q.priv.x;
  assign user_r_o = perm_q.user.r;
  assign user_w_o = perm_q.user.w;
  assign user_x_o = perm_q.user.x;
endmodule

// File: rtl/perm_decode_chk.sv
module perm_decode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       regime_i,
  input logic [1:0] ap_i,
  input logic       pxn_i,
  input logic       hier_dis_i,
  input logic       valid_o,
  input logic       priv_r_o,
  input logic       priv_w_o,
  input logic       priv_x_o,
  input logic       user_r_o,
  input logic       user_w_o,
  input logic       user_x_o
);
  logic past_ok;
  logic [5:0] outs;

  assign outs = {priv_r_o, priv_w_o, priv_x_o, user_r_o, user_w_o, user_x_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> $stable(outs));

  // R3
  single_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && $past(regime_i)) |->
      (!user_r_o && !user_w_o && !user_x_o && priv_r_o));

  // R2
  pxn_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && !$past(regime_i) && ($past(pxn_i) || $past(ap_i) == 2'b01))
      |-> !priv_x_o);

  // R7
  hier_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && !$past(regime_i) && $past(hier_dis_i) && $past(ap_i) == 2'b01)
      |-> (user_r_o && user_w_o));
endmodule

bind perm_decode_top perm_decode_chk i_perm_decode_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .regime_i   (regime_i),
  .ap_i       (ap_i),
  .pxn_i      (pxn_i),
  .hier_dis_i (hier_dis_i),
  .valid_o    (valid_o),
  .priv_r_o   (priv_r_o),
  .priv_w_o   (priv_w_o),
  .priv_x_o   (priv_x_o),
  .user_r_o   (user_r_o),
  .user_w_o   (user_w_o),
  .user_x_o   (user_x_o)
);

// File: tb/test_perm_decode_top.sv
`timescale 1ns/1ps
module test_perm_decode_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       regime_i = 1'b0;
  logic [1:0] ap_i = '0;
  logic       pxn_i = 1'b0, uxn_i = 1'b0;
  logic [1:0] tbl_ap_i = '0;
  logic       tbl_pxn_i = 1'b0, tbl_uxn_i = 1'b0, hier_dis_i = 1'b0;
  logic       valid_o, priv_r_o, priv_w_o, priv_x_o, user_r_o, user_w_o, user_x_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [5:0] exp_q[$];
  logic [5:0] last_seen = '0;
  int sent = 0, recv = 0;

  always #2.5 clk_i = ~clk_i;

  perm_decode_top i_perm_decode_top (.*);

  function automatic logic [5:0] model(logic reg1, logic [1:0] ap, logic pxn, logic uxn,
                                       logic [1:0] tap, logic tpxn, logic tuxn, logic hd);
    logic pr, pw, px, ur, uw, ux;
    if (!reg1) begin
      case (ap) // R1
        2'b00: {pr, pw, ur, uw} = 4'b1100;
        2'b01: {pr, pw, ur, uw} = 4'b1111;
        2'b10: {pr, pw, ur, uw} = 4'b1000;
        default: {pr, pw, ur, uw} = 4'b1010;
      endcase
      px = (pxn == 1'b0) && (ap != 2'b01); // R2
      ux = !uxn;
      if (!hd) begin
        case (tap) // R4
          2'b01: begin ur = 0; uw = 0; end
          2'b10: begin pw = 0; uw = 0; end
          2'b11: begin pw = 0; ur = 0; uw = 0; end
          default: ;
        endcase
        if (tpxn) px = 0; // R6
        if (tuxn) ux = 0;
      end
    end else begin
      pr = 1; pw = !ap[1]; px = !uxn; ur = 0; uw = 0; ux = 0; // R3
      if (!hd) begin // R5
        if (tap[1]) pw = 0;
        if (tuxn) px = 0;
      end
    end
    return {pr, pw, px, ur, uw, ux};
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic reg1, logic [1:0] ap, logic pxn, logic uxn,
                       logic [1:0] tap, logic tpxn, logic tuxn, logic hd);
    @(negedge clk_i);
    valid_i = 1; regime_i = reg1; ap_i = ap; pxn_i = pxn; uxn_i = uxn;
    tbl_ap_i = tap; tbl_pxn_i = tpxn; tbl_uxn_i = tuxn; hier_dis_i = hd;
    exp_q.push_back(model(reg1, ap, pxn, uxn, tap, tpxn, tuxn, hd));
    sent++;
  endtask

  task automatic idle(int n, bit scramble);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      valid_i = 0;
      if (scramble) begin
        regime_i = ~regime_i; ap_i = ap_i + 2'd1; pxn_i = ~pxn_i; uxn_i = ~uxn_i;
        tbl_ap_i = ~tbl_ap_i; hier_dis_i = ~hier_dis_i;
      end
    end
  endtask

  // monitor: pops one expected item per valid result
  always @(negedge clk_i) begin
    logic [5:0] act;
    if (rst_ni && !done) begin
      act = {priv_r_o, priv_w_o, priv_x_o, user_r_o, user_w_o, user_x_o};
      if (valid_o) begin
        recv++;
        if (exp_q.size() == 0) check("R8 extra result", 1'b1, 1'b0);
        else check(regime_i_tag(exp_q[0]), act, exp_q.pop_front());
        last_seen = act;
      end else if (recv > 0) begin
        check("R9 hold while idle", act, last_seen);
      end
    end
  end

  function automatic string regime_i_tag(logic [5:0] e);
    return (e[2:0] == 3'b000) ? "R1 R3 R4 R5 R6 R7" : "R1 R2 R4 R6 R7";
  endfunction

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset valid", {5'b0, valid_o}, 6'b0);
    check("R10 reset perms", {priv_r_o, priv_w_o, priv_x_o, user_r_o, user_w_o, user_x_o}, 6'b0);
    rst_ni = 1;
    for (int r = 0; r < 2; r++)
      for (int hd = 0; hd < 2; hd++)
        for (int ap = 0; ap < 4; ap++)
          for (int x = 0; x < 4; x++)
            for (int t = 0; t < 4; t++)
              for (int tx = 0; tx < 4; tx++) begin
                drive(r[0], ap[1:0], x[1], x[0], t[1:0], tx[1], tx[0], hd[0]);
                if (((ap + t + tx) % 7) == 0) idle(2, 1'b1);
              end
    idle(4, 1'b1);
    check("R8 result count", 6'(recv), 6'(sent));
    check("R8 queue drained", 6'(exp_q.size()), 6'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule